// File: doc/BRIEF.md
# Banked Data Memory with Per-Bank Arbitration

This block is a 64 KB local data memory built from eight single-port physical banks of 512 lines, each line 128 bits wide. Adjacent physical banks are paired, and the pair is interleaved on 128-bit line boundaries. Software therefore sees four logical banks of 16 KB, and two consecutive lines fall in different physical banks, so they can be accessed in the same cycle. A number of requester ports share the banks: two load ports, one store port and DMA ports in the intended use. Each port presents a byte address, a read/write select, a full 128-bit line of write data and one write enable per 32-bit word.

Every physical bank has its own round-robin arbiter. Requests to different banks proceed in parallel. When several ports hit the same bank in one cycle, one port is granted and the others see `stall`. A stalled port keeps its request on the inputs, and the arbiter takes it again in the next cycle. Read data returns one cycle after the grant.

The two lowest physical banks store a single-error-correcting, double-error-detecting code beside each 32-bit word. The other six banks store one even-parity bit per word. Each read returns per-word error flags together with the data.

Top module: `bm_top`

## Requirements
- R1: A byte address is split as follows. Bits [3:0] select a byte in a line and are ignored. Bit 4 selects the member of a bank pair. Bits [4+IW:5] give the line index, where IW = log2(LINES). The two top bits give the logical bank. The physical bank is 2*logical + bit4, so address 0 is line 0 of physical bank 0.
- R2: A write changes 32-bit word w (bits 32w+31:32w of the line) only when wstrb[w] is 1. Words whose strobe is 0 keep their previous contents.
- R3: A read granted in cycle t raises rvalid and presents rdata in cycle t+1. A granted write produces no rvalid.
- R4: In physical banks 0 and 1, each word is stored as {7 check bits, 32 data bits}, with word w at stored bits [39w+38:39w]. A single flipped stored bit, in the data or in a check bit, returns the corrected word and sets err_corr[w].
- R5: In banks 0 and 1, two flipped bits in one word set err_uncorr[w], leave err_corr[w] at 0 and return the stored data bits unchanged.
- R6: In physical banks 2 to 7, each word is stored as {even parity bit, 32 data bits} at stored bits [33w+32:33w]. A single flipped bit sets err_par[w] and returns the stored data unchanged. err_corr and err_uncorr stay 0 for these banks.
- R7: Each physical bank grants at most one port per cycle. Ports that address different banks are all granted in the same cycle.
- R8: stall[p] is high exactly when req[p] is high and the port is not granted. A port that keeps its request after a stall is granted in a later cycle without reissuing it.
- R9: Each bank's round-robin priority begins at port 0 after reset. After a grant to port g, the search starts at port g+1 (mod NP), so a port that keeps its request waits no more than NP-1 cycles.
- R10: A read of an unmodified word returns the written data with all three error flags at 0.
- R11: During and right after reset, rvalid and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NP | Per-port access request, held while stalled |
| we | input | NP | Per-port write select (1 = write) |
| addr | input | NP x AW | Per-port byte address, AW = IW + 7 |
| wdata | input | NP x 128 | Per-port write line |
| wstrb | input | NP x 4 | Per-port write enable for each 32-bit word |
| gnt | output | NP | Request accepted this cycle |
| stall | output | NP | Request refused this cycle, retry next cycle |
| rvalid | output | NP | Read data valid (one cycle after a read grant) |
| rdata | output | NP x 128 | Read line, corrected where possible |
| err_corr | output | NP x 4 | Per-word corrected single-bit error |
| err_uncorr | output | NP x 4 | Per-word detected double-bit error |
| err_par | output | NP x 4 | Per-word parity mismatch |

## Verification
The bench uses a four-line configuration and writes, then reads back, every line of all eight banks. The port used for each access rotates, so that a wrong bank decode, line decode or read return path shows up as a data mismatch. Stored bits are then flipped one at a time and two at a time, in a data bit, a check bit and the parity bit. This separates the correct, detect and parity paths and shows which banks carry which code. Arbitration is tried with all ports on one bank, with sparse subsets of ports after the pointer has moved, with ports on distinct banks, and with two lines of one pair against two lines of one bank. These cases tell round-robin order apart from fixed priority, and interleaving apart from plain linear banking.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int WORD_W      = 32;
  localparam int WPL         = 4;               // words per line
  localparam int LINE_W      = WORD_W * WPL;
  localparam int NUM_BANKS   = 8;
  localparam int ECC_BANKS   = 2;
  localparam int BK_W        = $clog2(NUM_BANKS);
  localparam int LB_W        = $clog2(NUM_BANKS / 2);
  localparam int OFF_W       = $clog2(LINE_W / 8);
  localparam int ECC_CHK_W   = 7;
  localparam int HAM_POS     = WORD_W + ECC_CHK_W - 1;  // highest Hamming position (38)
  localparam int ECC_WORD_W  = WORD_W + ECC_CHK_W;
  localparam int PAR_WORD_W  = WORD_W + 1;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              corr;
    logic              uncorr;
  } ecc_res_t;

  // Hamming check bits over positions 1..HAM_POS; data fills non-power-of-two slots.
  function automatic logic [ECC_CHK_W-1:0] ecc_gen(input logic [WORD_W-1:0] d);
    logic [ECC_CHK_W-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p <= HAM_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < ECC_CHK_W - 1; k++) begin
          if (((p >> k) & 1) == 1) c[k] = c[k] ^ d[di];
        end
        di++;
      end
    end
    c[ECC_CHK_W-1] = (^d) ^ (^c[ECC_CHK_W-2:0]);
    return c;
  endfunction

  function automatic ecc_res_t ecc_check(input logic [WORD_W-1:0] d,
                                         input logic [ECC_CHK_W-1:0] c);
    ecc_res_t r;
    logic [ECC_CHK_W-1:0] cc;
    logic [ECC_CHK_W-2:0] syn;
    logic ovr;
    int di;
    cc  = ecc_gen(d);
    syn = cc[ECC_CHK_W-2:0] ^ c[ECC_CHK_W-2:0];
    ovr = (^d) ^ (^c);
    r.data   = d;
    r.corr   = 1'b0;
    r.uncorr = 1'b0;
    if (ovr) begin
      if (int'(syn) > HAM_POS) begin
        r.uncorr = 1'b1;
      end else begin
        r.corr = 1'b1;
        di = 0;
        for (int p = 1; p <= HAM_POS; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (int'(syn) == p) r.data[di] = ~d[di];
            di++;
          end
        end
      end
    end else if (syn != '0) begin
      r.uncorr = 1'b1;
    end
    return r;
  endfunction

  function automatic logic par_gen(input logic [WORD_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/bm_rr_arb.sv
module bm_rr_arb #(
  parameter int N = 5,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nxt;
  logic          any_gnt;

  always_comb begin
    int idx;
    gnt     = '0;
    any_gnt = 1'b0;
    ptr_nxt = ptr_q;
    for (int i = 0; i < N; i++) begin
      idx = (int'(ptr_q) + i) % N;
      if (!any_gnt && req[idx]) begin
        gnt[idx] = 1'b1;
        any_gnt  = 1'b1;
        ptr_nxt  = PW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (any_gnt) ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/bm_bank.sv
module bm_bank
  import bm_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter bit USE_ECC = 1'b0,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [LINE_W-1:0] wdata,
  input  logic [WPL-1:0]    wstrb,
  output logic [LINE_W-1:0] rdata,
  output logic [WPL-1:0]    corr,
  output logic [WPL-1:0]    uncorr,
  output logic [WPL-1:0]    par_err
);
  localparam int SW  = USE_ECC ? ECC_WORD_W : PAR_WORD_W;
  localparam int LSW = SW * WPL;

  logic [LSW-1:0] mem [DEPTH];
  logic [LSW-1:0] rd_q;
  logic [LSW-1:0] enc_line;

  if (USE_ECC) begin : g_ecc
    for (genvar w = 0; w < WPL; w++) begin : g_w
      ecc_res_t res;
      assign enc_line[w*SW +: SW] = {ecc_gen(wdata[w*WORD_W +: WORD_W]),
                                     wdata[w*WORD_W +: WORD_W]};
      assign res = ecc_check(rd_q[w*SW +: WORD_W], rd_q[w*SW+WORD_W +: ECC_CHK_W]);
      assign rdata[w*WORD_W +: WORD_W] = res.data;
      assign corr[w]    = res.corr;
      assign uncorr[w]  = res.uncorr;
      assign par_err[w] = 1'b0;
    end
  end else begin : g_par
    for (genvar w = 0; w < WPL; w++) begin : g_w
      assign enc_line[w*SW +: SW] = {par_gen(wdata[w*WORD_W +: WORD_W]),
                                     wdata[w*WORD_W +: WORD_W]};
      assign rdata[w*WORD_W +: WORD_W] = rd_q[w*SW +: WORD_W];
      assign par_err[w] = par_gen(rd_q[w*SW +: WORD_W]) ^ rd_q[w*SW + WORD_W];
      assign corr[w]    = 1'b0;
      assign uncorr[w]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int w = 0; w < WPL; w++) begin
          if (wstrb[w]) mem[idx][w*SW +: SW] <= enc_line[w*SW +: SW];
        end
      end else begin
        rd_q <= mem[idx];
      end
    end
  end
endmodule

// File: rtl/bm_top.sv
module bm_top
  import bm_pkg::*;
#(
  parameter int NP    = 5,
  parameter int LINES = 512,
  localparam int IW = $clog2(LINES),
  localparam int AW = OFF_W + 1 + IW + LB_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NP-1:0]               req,
  input  logic [NP-1:0]               we,
  input  logic [NP-1:0][AW-1:0]       addr,
  input  logic [NP-1:0][LINE_W-1:0]   wdata,
  input  logic [NP-1:0][WPL-1:0]      wstrb,
  output logic [NP-1:0]               gnt,
  output logic [NP-1:0]               stall,
  output logic [NP-1:0]               rvalid,
  output logic [NP-1:0][LINE_W-1:0]   rdata,
  output logic [NP-1:0][WPL-1:0]      err_corr,
  output logic [NP-1:0][WPL-1:0]      err_uncorr,
  output logic [NP-1:0][WPL-1:0]      err_par
);
  // decoded per-port target
  logic [NP-1:0][BK_W-1:0] port_bank;
  logic [NP-1:0][IW-1:0]   port_line;
  logic                    unused_lo;

  // named internal events (observed by the bound checker)
  logic [NUM_BANKS-1:0][NP-1:0]     bank_req;
  logic [NUM_BANKS-1:0][NP-1:0]     bank_gnt;
  logic [NUM_BANKS-1:0][LINE_W-1:0] bank_rdata;
  logic [NUM_BANKS-1:0][WPL-1:0]    bank_corr;
  logic [NUM_BANKS-1:0][WPL-1:0]    bank_uncorr;
  logic [NUM_BANKS-1:0][WPL-1:0]    bank_par;

  // read return tracking
  logic [NP-1:0]           rv_q;
  logic [NP-1:0][BK_W-1:0] rb_q;

  function automatic logic [BK_W-1:0] phys_bank(input logic [AW-1:0] a);
    return {a[AW-1 -: LB_W], a[OFF_W]};
  endfunction

  function automatic logic [IW-1:0] line_of(input logic [AW-1:0] a);
    return a[OFF_W+1 +: IW];
  endfunction

  always_comb begin
    unused_lo = 1'b0;
    for (int p = 0; p < NP; p++) begin
      port_bank[p] = phys_bank(addr[p]);
      port_line[p] = line_of(addr[p]);
      unused_lo    = unused_lo ^ (^addr[p][OFF_W-1:0]);
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NP; p++) begin
        bank_req[b][p] = req[p] && (port_bank[p] == BK_W'(b));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              b_we;
    logic [IW-1:0]     b_idx;
    logic [LINE_W-1:0] b_wd;
    logic [WPL-1:0]    b_ws;

    bm_rr_arb #(.N(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (bank_req[b]),
      .gnt   (bank_gnt[b])
    );

    always_comb begin
      b_we  = 1'b0;
      b_idx = '0;
      b_wd  = '0;
      b_ws  = '0;
      for (int p = 0; p < NP; p++) begin
        if (bank_gnt[b][p]) begin
          b_we  = we[p];
          b_idx = port_line[p];
          b_wd  = wdata[p];
          b_ws  = wstrb[p];
        end
      end
    end

    bm_bank #(.DEPTH(LINES), .USE_ECC(b < ECC_BANKS)) u_bank (
      .clk     (clk),
      .en      (|bank_gnt[b]),
      .we      (b_we),
      .idx     (b_idx),
      .wdata   (b_wd),
      .wstrb   (b_ws),
      .rdata   (bank_rdata[b]),
      .corr    (bank_corr[b]),
      .uncorr  (bank_uncorr[b]),
      .par_err (bank_par[b])
    );
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      gnt[p] = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) gnt[p] = gnt[p] | bank_gnt[b][p];
      stall[p] = req[p] & ~gnt[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= '0;
      rb_q <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        rv_q[p] <= gnt[p] & ~we[p];
        rb_q[p] <= port_bank[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rvalid[p]     = rv_q[p];
      rdata[p]      = bank_rdata[rb_q[p]];
      err_corr[p]   = bank_corr[rb_q[p]]   & {WPL{rv_q[p]}};
      err_uncorr[p] = bank_uncorr[rb_q[p]] & {WPL{rv_q[p]}};
      err_par[p]    = bank_par[rb_q[p]]    & {WPL{rv_q[p]}};
    end
  end
endmodule

// File: rtl/bm_chk.sv
module bm_chk
  import bm_pkg::*;
#(
  parameter int NP = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NP-1:0]                req,
  input logic [NP-1:0]                we,
  input logic [NP-1:0]                gnt,
  input logic [NP-1:0]                stall,
  input logic [NP-1:0]                rvalid,
  input logic [NP-1:0][WPL-1:0]       err_corr,
  input logic [NP-1:0][WPL-1:0]       err_uncorr,
  input logic [NUM_BANKS-1:0][NP-1:0] bank_gnt
);
  localparam int CW = $clog2(NP + 1) + 1;
  logic [NP-1:0][CW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else begin
      for (int p = 0; p < NP; p++) wcnt[p] <= stall[p] ? wcnt[p] + 1'b1 : '0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    // R7
    one_grant_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_gnt[b]));
  end

  for (genvar p = 0; p < NP; p++) begin : g_p
    // R8
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |-> req[p]);
    // R9
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall[p] |-> (int'(wcnt[p]) < NP - 1));
    // R3
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[p] && !we[p]) |=> rvalid[p]);
    // R3
    no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt[p] && !we[p]) |=> !rvalid[p]);
    // R5
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_corr[p] & err_uncorr[p]) == '0);
  end
endmodule

bind bm_top bm_chk #(.NP(NP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .we         (we),
  .gnt        (gnt),
  .stall      (stall),
  .rvalid     (rvalid),
  .err_corr   (err_corr),
  .err_uncorr (err_uncorr),
  .bank_gnt   (bank_gnt)
);

// File: tb/bm_top_tb_top.sv
module bm_top_tb_top;
  import bm_pkg::*;
  localparam int NP    = 5;
  localparam int LINES = 4;
  localparam int AW    = 4 + 1 + 2 + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]             req = '0;
  logic [NP-1:0]             we = '0;
  logic [NP-1:0][AW-1:0]     addr = '0;
  logic [NP-1:0][127:0]      wdata = '0;
  logic [NP-1:0][3:0]        wstrb = '0;
  logic [NP-1:0]             gnt, stall, rvalid;
  logic [NP-1:0][127:0]      rdata;
  logic [NP-1:0][3:0]        err_corr, err_uncorr, err_par;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int rr_ptr = 0;
  logic [127:0] shadow [8][LINES];

  always #2 clk = ~clk;

  bm_top #(.NP(NP), .LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .gnt(gnt), .stall(stall),
    .rvalid(rvalid), .rdata(rdata), .err_corr(err_corr),
    .err_uncorr(err_uncorr), .err_par(err_par));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int b, input int line);
    return AW'(((b >> 1) << 7) | (line << 5) | ((b & 1) << 4));
  endfunction

  function automatic logic [127:0] pat(input int a, input int salt);
    logic [31:0] x;
    x = 32'(a);
    return {x * 32'h01010101 ^ 32'(salt), ~x, x * 32'd7 + 32'(salt), x ^ 32'h5A5A0000 ^ 32'(salt << 8)};
  endfunction

  task automatic access(input int p, input bit w, input logic [AW-1:0] a,
                        input logic [127:0] d, input logic [3:0] s,
                        output logic [127:0] rd, output logic [3:0] fc,
                        output logic [3:0] fu, output logic [3:0] fp,
                        output bit gok, output bit vok);
    @(negedge clk);
    req[p] = 1'b1; we[p] = w; addr[p] = a; wdata[p] = d; wstrb[p] = s;
    #1 gok = gnt[p];
    @(negedge clk);
    req[p] = 1'b0; we[p] = 1'b0;
    vok = rvalid[p]; rd = rdata[p];
    fc = err_corr[p]; fu = err_uncorr[p]; fp = err_par[p];
  endtask

  // rr model: first requester at or after ptr
  function automatic logic [NP-1:0] rr_pick(input logic [NP-1:0] pend, input int ptr);
    for (int i = 0; i < NP; i++) begin
      if (pend[(ptr + i) % NP]) return NP'(1) << ((ptr + i) % NP);
    end
    return '0;
  endfunction

  task automatic rr_round(input logic [NP-1:0] mask);
    logic [NP-1:0] pend;
    logic [NP-1:0] exp;
    pend = mask;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (mask[p]) begin req[p] = 1'b1; we[p] = 1'b0; addr[p] = mk(3, p % LINES); end
    end
    while (pend != '0) begin
      #1;
      exp = rr_pick(pend, rr_ptr);
      chk(gnt == exp, "R9 round-robin grant order", 128'(gnt), 128'(exp));
      chk(stall == (pend & ~exp), "R8 stall of waiting ports", 128'(stall), 128'(pend & ~exp));
      for (int p = 0; p < NP; p++) if (exp[p]) rr_ptr = (p + 1) % NP;
      pend = pend & ~exp;
      @(negedge clk);
      for (int p = 0; p < NP; p++) if (exp[p]) req[p] = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired (R8 R9 progress) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] rd, e;
    logic [3:0] fc, fu, fp;
    bit gok, vok;
    logic g0, g1;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rvalid == '0, "R11 rvalid in reset", 128'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == '0 && gnt == '0, "R11 idle after reset", 128'({rvalid, gnt}), 0);
    chk(err_corr == '0 && err_uncorr == '0 && err_par == '0, "R11 flags after reset",
        128'({err_corr, err_uncorr, err_par}), 0);

    // R9 round robin on bank 3, pointer starts at 0
    rr_round(5'b11111);
    rr_round(5'b01010);
    rr_round(5'b10001);
    rr_round(5'b11100);

    // R1 R2 R10 exhaustive sweep
    for (int b = 0; b < 8; b++) begin
      for (int l = 0; l < LINES; l++) begin
        shadow[b][l] = pat(b * LINES + l, 17);
        access(2, 1'b1, mk(b, l), shadow[b][l], 4'hF, rd, fc, fu, fp, gok, vok);
        chk(gok, "R7 lone write granted", 128'(gok), 1);
        chk(!vok, "R3 write gives no rvalid", 128'(vok), 0);
      end
    end
    for (int b = 0; b < 8; b++) begin
      for (int l = 0; l < LINES; l++) begin
        access((b + l) % NP, 1'b0, mk(b, l) | AW'(b + 3 * l), '0, 4'h0, rd, fc, fu, fp, gok, vok);
        chk(vok, "R3 read returns rvalid", 128'(vok), 1);
        chk(rd == shadow[b][l], "R1 bank/line decode readback", rd, shadow[b][l]);
        chk(fc == 0 && fu == 0 && fp == 0, "R10 clean read flags", 128'({fc, fu, fp}), 0);
      end
    end

    // R2 partial write strobes
    e = pat(99, 5);
    access(2, 1'b1, mk(5, 1), e, 4'b0101, rd, fc, fu, fp, gok, vok);
    shadow[5][1] = {shadow[5][1][127:96], e[95:64], shadow[5][1][63:32], e[31:0]};
    access(0, 1'b0, mk(5, 1), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == shadow[5][1], "R2 strobe 0101 merge", rd, shadow[5][1]);
    access(2, 1'b1, mk(0, 2), e, 4'b1000, rd, fc, fu, fp, gok, vok);
    shadow[0][2] = {e[127:96], shadow[0][2][95:0]};
    access(1, 1'b0, mk(0, 2), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == shadow[0][2] && fc == 0, "R2 strobe 1000 in ECC bank", rd, shadow[0][2]);

    // R7 distinct banks all granted at once, including both halves of a pair
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin req[p] = 1'b1; we[p] = 1'b0; addr[p] = mk(p, 0); end
    #1 chk(gnt == '1, "R7 distinct banks parallel grant", 128'(gnt), 128'({NP{1'b1}}));
    @(negedge clk);
    req = '0;
    for (int p = 0; p < NP; p++)
      chk(rvalid[p] && rdata[p] == shadow[p][0], "R7 parallel read data", rdata[p], shadow[p][0]);

    // R8 same-bank conflict: lines 0 and 1 of bank 0
    @(negedge clk);
    req[0] = 1'b1; we[0] = 1'b0; addr[0] = mk(0, 0);
    req[1] = 1'b1; we[1] = 1'b0; addr[1] = mk(0, 1);
    #1 g0 = gnt[0]; g1 = gnt[1];
    chk(g0 ^ g1, "R7 one grant on shared bank", 128'({g0, g1}), 1);
    chk(stall[0] == !g0 && stall[1] == !g1, "R8 loser stalls", 128'(stall[1:0]), 128'({!g1, !g0}));
    @(negedge clk);
    if (g0) begin
      chk(rdata[0] == shadow[0][0], "R8 first winner data", rdata[0], shadow[0][0]);
      req[0] = 1'b0;
    end else begin
      chk(rdata[1] == shadow[0][1], "R8 first winner data", rdata[1], shadow[0][1]);
      req[1] = 1'b0;
    end
    #1 chk(gnt[g0 ? 1 : 0] && stall == '0, "R8 retried request granted", 128'(gnt), 128'(g0 ? 2 : 1));
    @(negedge clk);
    req = '0;
    if (g0) chk(rdata[1] == shadow[0][1], "R8 retried read data", rdata[1], shadow[0][1]);
    else    chk(rdata[0] == shadow[0][0], "R8 retried read data", rdata[0], shadow[0][0]);

    // R4 single data bit flip, bank 0 line 0 word 0 bit 3
    dut_i.g_bank[0].u_bank.mem[0][3] = ~dut_i.g_bank[0].u_bank.mem[0][3];
    access(0, 1'b0, mk(0, 0), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == shadow[0][0], "R4 corrected data", rd, shadow[0][0]);
    chk(fc == 4'b0001 && fu == 0, "R4 corr flag word0", 128'({fc, fu}), 128'(8'h10));
    dut_i.g_bank[0].u_bank.mem[0][3] = ~dut_i.g_bank[0].u_bank.mem[0][3];

    // R4 check bit flip, bank 1 line 2 word 2 check bit 4 -> 2*39+32+4
    dut_i.g_bank[1].u_bank.mem[2][114] = ~dut_i.g_bank[1].u_bank.mem[2][114];
    access(3, 1'b0, mk(1, 2), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == shadow[1][2] && fc == 4'b0100 && fu == 0, "R4 check-bit flip", rd, shadow[1][2]);
    dut_i.g_bank[1].u_bank.mem[2][114] = ~dut_i.g_bank[1].u_bank.mem[2][114];

    // R5 double flip, bank 0 line 3 word 1 data bits 0 and 7
    dut_i.g_bank[0].u_bank.mem[3][39] = ~dut_i.g_bank[0].u_bank.mem[3][39];
    dut_i.g_bank[0].u_bank.mem[3][46] = ~dut_i.g_bank[0].u_bank.mem[3][46];
    e = shadow[0][3] ^ (128'(1) << 32) ^ (128'(1) << 39);
    access(4, 1'b0, mk(0, 3), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == e, "R5 raw data on double error", rd, e);
    chk(fu == 4'b0010 && fc == 0, "R5 uncorr flag word1", 128'({fc, fu}), 128'(8'h02));
    dut_i.g_bank[0].u_bank.mem[3][39] = ~dut_i.g_bank[0].u_bank.mem[3][39];
    dut_i.g_bank[0].u_bank.mem[3][46] = ~dut_i.g_bank[0].u_bank.mem[3][46];

    // R6 parity data flip, bank 6 line 1 word 3 bit 10 -> 3*33+10
    dut_i.g_bank[6].u_bank.mem[1][109] = ~dut_i.g_bank[6].u_bank.mem[1][109];
    e = shadow[6][1] ^ (128'(1) << 106);
    access(1, 1'b0, mk(6, 1), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == e, "R6 raw data on parity error", rd, e);
    chk(fp == 4'b1000 && fc == 0 && fu == 0, "R6 par flag word3", 128'({fc, fu, fp}), 128'(12'h008));
    dut_i.g_bank[6].u_bank.mem[1][109] = ~dut_i.g_bank[6].u_bank.mem[1][109];

    // R6 parity bit flip, bank 2 line 0 word 0 bit 32
    dut_i.g_bank[2].u_bank.mem[0][32] = ~dut_i.g_bank[2].u_bank.mem[0][32];
    access(2, 1'b0, mk(2, 0), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == shadow[2][0] && fp == 4'b0001 && fc == 0, "R6 parity bit flip", rd, shadow[2][0]);
    dut_i.g_bank[2].u_bank.mem[0][32] = ~dut_i.g_bank[2].u_bank.mem[0][32];

    // R10 restored word reads clean
    access(0, 1'b0, mk(0, 0), '0, 4'h0, rd, fc, fu, fp, gok, vok);
    chk(rd == shadow[0][0] && fc == 0 && fu == 0 && fp == 0, "R10 clean after restore", rd, shadow[0][0]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule